// File: doc/BRIEF.md
# CPU clock frequency-change sequencer

This block moves a CPU clock domain between five performance levels without software stepping through the individual register writes. A single request gives the level the domain is at now and the level it should reach. Level 0 is the fastest (1200 MHz), then 1000, 800, 500 and 200 MHz at level 4. The block drives the core clock source select, the PLL configuration word and two divider registers. It waits on the status inputs that the clock controller returns, and it pulses `done` when the domain is running at the new level.

The order of the work follows the direction of the change. A speed-up first slows the derived clocks through the dividers and only then raises the PLL. A slow-down lowers the PLL first and fixes the dividers afterwards. When two levels share the PLL feedback and pre-divider settings, only the 3-bit post-divider is rewritten and the core stays on the main PLL. Otherwise the core is parked on the alternate PLL while the main PLL relocks. The relock is timed by an internal counter and is qualified by the lock input.

Top module: `cpu_clk_seq`

## Requirements
- R1: After any completed change to level L, `pll_cfg` holds M in bits 25:16, P in bits 13:8 and S in bits 2:0, with all other bits zero. The (M,P,S) values for levels 0..4 are (150,3,1), (250,6,1), (200,6,1), (250,6,2) and (200,6,3).
- R2: After a change to level L, `div0_cfg` holds seven 4-bit fields, with field i at bits 4i+3:4i. Fields 0..6 are core, core-memory A, core-memory B, peripheral, trace bus, debug APB and PLL output. Levels 0 and 1 use 0,3,7,3,4,1,7. Levels 2 and 3 use 0,3,7,3,3,1,7. Level 4 uses 0,1,3,1,3,1,0.
- R3: After a change to level L, `div1_cfg` bits 6:4 hold the copy divider (5,4,3,3,3 for levels 0..4) and bits 2:0 hold the monitor divider (0). Every other bit keeps the value of parameter `DIV1_INIT`.
- R4: When the target index is lower than the current index, the divider registers are written before `pll_cfg` changes. When the target index is higher, `pll_cfg` changes before the divider registers.
- R5: A full PLL change happens only when bits 31:8 of the two levels' configuration words differ. It raises `core_src_alt`, waits until `mux_stat` reads 2, loads the lock counter and then writes the whole configuration word.
- R6: During a full change, `core_src_alt` falls only after at least `LOCK_TIME` cycles have passed since the configuration write and `pll_lock` is high.
- R7: After lowering `core_src_alt`, the block waits until `mux_stat` reads 1 before it continues. `done` is never high while `core_src_alt` is high.
- R8: When bits 31:8 match, only `pll_cfg` bits 2:0 change and `core_src_alt` stays low for the whole change.
- R9: `div1_cfg` is written only after every bit of `div0_busy` is clear. The change does not finish until `div1_busy` is clear.
- R10: A request whose current and target indices are equal raises `done` in the next cycle and changes no output.
- R11: `busy` is high from the cycle after a change is accepted until it finishes. Requests that arrive while `busy` is high are ignored.
- R12: Each change raises `done` for exactly one cycle, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Change request strobe |
| req_cur | input | 3 | Level index the domain is at |
| req_tgt | input | 3 | Level index to move to |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle completion pulse |
| core_src_alt | output | 1 | Core source select, 1 = alternate PLL |
| mux_stat | input | 3 | Source mux status: 1 main, 2 alternate, other = switching |
| pll_cfg | output | 32 | PLL configuration word (M, P, S) |
| pll_lock | input | 1 | PLL lock indication |
| div0_cfg | output | 28 | First divider group, seven 4-bit fields |
| div0_busy | input | 7 | Per-field busy flags of the first group |
| div1_cfg | output | 32 | Second divider group |
| div1_busy | input | 2 | Busy flags of the second group |

## Verification
On every cycle the assertions check the following. Core-source and PLL-word changes happen only after the mux reports the alternate source. The return to the main PLL respects the lock counter and the lock input. The second divider group is written only with the first group idle. `done` is never seen with `busy` or the alternate source. The bench's sweep over every ordered pair of levels is what shows the exact register contents per level, the divider-versus-PLL order for each direction and the choice between the S-only path and the full path. The scenarios also cover the immediate completion of equal-index requests and the dropping of requests made while busy.

// File: rtl/clkseq_pkg.sv
// Shared constants, level tables and state type for the clock-change sequencer.
// Assumes five levels, index 0 the fastest; out-of-range indices map to level 4.
package clkseq_pkg;
    localparam int LVL_W   = 3;
    localparam int DIV0_N  = 7;
    localparam int DIV_FW  = 4;
    localparam int DIV0_W  = DIV0_N * DIV_FW;
    localparam int CFG_W   = 32;
    localparam int MP_LSB  = 8;
    localparam logic [2:0]  MUXST_MAIN = 3'd1;
    localparam logic [2:0]  MUXST_ALT  = 3'd2;
    localparam logic [31:0] DIV1_FIELD_MASK = 32'h0000_0077;

    typedef enum logic [3:0] {
        ST_IDLE, ST_D0_WR, ST_D0_WAIT, ST_D1_WR, ST_D1_WAIT,
        ST_ALT_REQ, ST_ALT_WAIT, ST_LOCK_LD, ST_MP_WR, ST_LOCK_WAIT,
        ST_MAIN_WAIT, ST_S_WR
    } seq_state_t;

    // PLL word for a level: M at 25:16, P at 13:8, S at 2:0.
    function automatic logic [CFG_W-1:0] cfg_word(input logic [LVL_W-1:0] lvl);
        logic [9:0] m;
        logic [5:0] p;
        logic [2:0] s;
        case (lvl)
            3'd0:    begin m = 10'd150; p = 6'd3; s = 3'd1; end
            3'd1:    begin m = 10'd250; p = 6'd6; s = 3'd1; end
            3'd2:    begin m = 10'd200; p = 6'd6; s = 3'd1; end
            3'd3:    begin m = 10'd250; p = 6'd6; s = 3'd2; end
            default: begin m = 10'd200; p = 6'd6; s = 3'd3; end
        endcase
        return {6'd0, m, 2'd0, p, 5'd0, s};
    endfunction

    // Upper part of the PLL word that decides whether a relock is needed.
    function automatic logic [CFG_W-MP_LSB-1:0] mp_key(input logic [LVL_W-1:0] lvl);
        logic [CFG_W-1:0] w;
        w = cfg_word(lvl);
        return w[CFG_W-1:MP_LSB];
    endfunction

    // First divider group, field 0 (core) in the lowest nibble.
    function automatic logic [DIV0_W-1:0] div0_word(input logic [LVL_W-1:0] lvl);
        logic [3:0] f_core, f_mem_a, f_mem_b, f_per, f_trc, f_dbg, f_pll;
        f_core = 4'd0; f_mem_a = 4'd3; f_mem_b = 4'd7; f_per = 4'd3;
        f_trc = 4'd3; f_dbg = 4'd1; f_pll = 4'd7;
        case (lvl)
            3'd0, 3'd1: f_trc = 4'd4;
            3'd2, 3'd3: f_trc = 4'd3;
            default: begin
                f_mem_a = 4'd1; f_mem_b = 4'd3; f_per = 4'd1; f_pll = 4'd0;
            end
        endcase
        return {f_pll, f_dbg, f_trc, f_per, f_mem_b, f_mem_a, f_core};
    endfunction

    // Second divider group fields: copy at 6:4, monitor at 2:0.
    function automatic logic [CFG_W-1:0] div1_fields(input logic [LVL_W-1:0] lvl);
        logic [2:0] copy_div;
        case (lvl)
            3'd0:    copy_div = 3'd5;
            3'd1:    copy_div = 3'd4;
            default: copy_div = 3'd3;
        endcase
        return {25'd0, copy_div, 1'b0, 3'd0};
    endfunction
endpackage

// File: rtl/clkseq_lock_timer.sv
// Lock-wait timer: a down-counter loaded with the lock time; reports lock
// only once the count has expired and the PLL lock input is high.
// Assumes load is a single-cycle strobe issued before the PLL word write.
module clkseq_lock_timer #(
    parameter int LOCK_TIME = 20,
    parameter int CNT_W     = $clog2(LOCK_TIME + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic pll_lock,
    output logic locked
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= CNT_W'(LOCK_TIME);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign locked = (cnt_q == '0) && pll_lock;
endmodule

// File: rtl/clkseq_div_bank.sv
// Divider register with a write mask: only bits set in WMASK take new data,
// the rest keep their reset value. Assumes writes are single-cycle strobes.
module clkseq_div_bank #(
    parameter int           W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0,
    parameter logic [W-1:0] WMASK     = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    // Merge the write data into the masked fields only.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= RESET_VAL;
        else if (wr_en) q <= (q & ~WMASK) | (wr_data & WMASK);
    end
endmodule

// File: rtl/cpu_clk_seq.sv
// Clock-change sequencer: accepts a (current, target) level request, orders
// divider and PLL updates by direction, takes the S-only shortcut when M and
// P match, parks the core on the alternate PLL during relock, pulses done.
// Assumes req_cur matches the level the domain is actually at.
module cpu_clk_seq
    import clkseq_pkg::*;
#(
    parameter int          LOCK_TIME  = 20,
    parameter int          INIT_LEVEL = 0,
    parameter logic [31:0] DIV1_INIT  = 32'h0013_0500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_cur,
    input  logic [LVL_W-1:0]  req_tgt,
    output logic              busy,
    output logic              done,
    output logic              core_src_alt,
    input  logic [2:0]        mux_stat,
    output logic [CFG_W-1:0]  pll_cfg,
    input  logic              pll_lock,
    output logic [DIV0_W-1:0] div0_cfg,
    input  logic [DIV0_N-1:0] div0_busy,
    output logic [CFG_W-1:0]  div1_cfg,
    input  logic [1:0]        div1_busy
);
    localparam logic [LVL_W-1:0]  INIT_L   = LVL_W'(INIT_LEVEL);
    localparam logic [CFG_W-1:0]  DIV1_RST = (DIV1_INIT & ~DIV1_FIELD_MASK) | div1_fields(INIT_L);
    localparam logic [DIV0_W-1:0] DIV0_RST = div0_word(INIT_L);

    seq_state_t       state_q, state_d, after_pll, after_div;
    logic [LVL_W-1:0] tgt_q;
    logic             faster_q, full_q, alt_q, done_q;
    logic [CFG_W-1:0] cfg_q, tgt_word;
    logic             accept, d0_we, d1_we, tmr_load, locked, mp_differ, same_req;

    assign tgt_word  = cfg_word(tgt_q);
    assign mp_differ = mp_key(req_cur) != mp_key(req_tgt);
    assign same_req  = req_valid && (req_cur == req_tgt);

    clkseq_lock_timer #(.LOCK_TIME(LOCK_TIME)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .pll_lock(pll_lock), .locked(locked)
    );

    clkseq_div_bank #(.W(DIV0_W), .RESET_VAL(DIV0_RST), .WMASK({DIV0_W{1'b1}})) u_div0 (
        .clk(clk), .rst_n(rst_n), .wr_en(d0_we), .wr_data(div0_word(tgt_q)), .q(div0_cfg)
    );

    clkseq_div_bank #(.W(CFG_W), .RESET_VAL(DIV1_RST), .WMASK(DIV1_FIELD_MASK)) u_div1 (
        .clk(clk), .rst_n(rst_n), .wr_en(d1_we), .wr_data(div1_fields(tgt_q)), .q(div1_cfg)
    );

    // Next state and single-cycle strobes of the sequence.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        d0_we    = 1'b0;
        d1_we    = 1'b0;
        tmr_load = 1'b0;
        after_pll = faster_q ? ST_IDLE : ST_D0_WR;
        after_div = faster_q ? (full_q ? ST_ALT_REQ : ST_S_WR) : ST_IDLE;
        case (state_q)
            ST_IDLE: begin
                if (req_valid && (req_cur != req_tgt)) begin
                    accept = 1'b1;
                    if (req_tgt < req_cur) state_d = ST_D0_WR;
                    else if (mp_differ)    state_d = ST_ALT_REQ;
                    else                   state_d = ST_S_WR;
                end
            end
            ST_D0_WR:     begin d0_we = 1'b1; state_d = ST_D0_WAIT; end
            ST_D0_WAIT:   if (div0_busy == '0) state_d = ST_D1_WR;
            ST_D1_WR:     begin d1_we = 1'b1; state_d = ST_D1_WAIT; end
            ST_D1_WAIT:   if (div1_busy == '0) state_d = after_div;
            ST_ALT_REQ:   state_d = ST_ALT_WAIT;
            ST_ALT_WAIT:  if (mux_stat == MUXST_ALT) state_d = ST_LOCK_LD;
            ST_LOCK_LD:   begin tmr_load = 1'b1; state_d = ST_MP_WR; end
            ST_MP_WR:     state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (locked) state_d = ST_MAIN_WAIT;
            ST_MAIN_WAIT: if (mux_stat == MUXST_MAIN) state_d = after_pll;
            ST_S_WR:      state_d = after_pll;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State, request capture, source select, PLL word and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tgt_q    <= INIT_L;
            faster_q <= 1'b0;
            full_q   <= 1'b0;
            alt_q    <= 1'b0;
            done_q   <= 1'b0;
            cfg_q    <= cfg_word(INIT_L);
        end else begin
            state_q <= state_d;
            done_q  <= ((state_q == ST_IDLE) && same_req) ||
                       ((state_q != ST_IDLE) && (state_d == ST_IDLE));
            if (accept) begin
                tgt_q    <= req_tgt;
                faster_q <= req_tgt < req_cur;
                full_q   <= mp_differ;
            end
            if (state_q == ST_ALT_REQ)             alt_q <= 1'b1;
            if ((state_q == ST_LOCK_WAIT) && locked) alt_q <= 1'b0;
            if (state_q == ST_MP_WR)               cfg_q <= tgt_word;
            if (state_q == ST_S_WR)                cfg_q[2:0] <= tgt_word[2:0];
        end
    end

    assign busy         = state_q != ST_IDLE;
    assign done         = done_q;
    assign core_src_alt = alt_q;
    assign pll_cfg      = cfg_q;
endmodule

// File: rtl/clkseq_chk.sv
// Protocol checker for the clock-change sequencer, bound to its top module.
// Assumes mux_stat and the busy flags come from a well-behaved controller.
module clkseq_chk #(
    parameter int LOCK_TIME = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        core_src_alt,
    input logic [2:0]  mux_stat,
    input logic [31:0] pll_cfg,
    input logic        pll_lock,
    input logic [27:0] div0_cfg,
    input logic [6:0]  div0_busy,
    input logic [31:0] div1_cfg
);
    logic [17:0] prev_mp;
    logic [15:0] since_mp;

    // Count edges since the last change of the M/P part of the PLL word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mp  <= pll_cfg[25:8];
            since_mp <= '0;
        end else begin
            prev_mp <= pll_cfg[25:8];
            if (pll_cfg[25:8] != prev_mp) since_mp <= '0;
            else if (since_mp != 16'hFFFF) since_mp <= since_mp + 1'b1;
        end
    end

    // R5
    mp_after_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_cfg[25:8]) |-> core_src_alt && ($past(mux_stat) == 3'd2));

    // R6
    lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_src_alt) |-> $past(pll_lock) && (since_mp >= 16'(LOCK_TIME - 1)));

    // R9
    div1_after_div0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div1_cfg) |-> ($past(div0_busy) == '0));

    // R4
    div_on_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div0_cfg) |-> !core_src_alt);

    // R7
    main_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !core_src_alt);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind cpu_clk_seq clkseq_chk #(.LOCK_TIME(LOCK_TIME)) u_clkseq_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .core_src_alt(core_src_alt),
    .mux_stat(mux_stat), .pll_cfg(pll_cfg), .pll_lock(pll_lock),
    .div0_cfg(div0_cfg), .div0_busy(div0_busy), .div1_cfg(div1_cfg)
);

// File: tb/tb_cpu_clk_seq.sv
`timescale 1ns/1ps
module tb_cpu_clk_seq;
    localparam int          LT    = 20;
    localparam logic [31:0] D1INI = 32'h0013_0500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cur = '0, req_tgt = '0;
    logic        busy, done, core_src_alt;
    logic [2:0]  mux_stat = 3'd1;
    logic [31:0] pll_cfg, div1_cfg;
    logic        pll_lock = 1'b1;
    logic [27:0] div0_cfg;
    logic [6:0]  div0_busy = '0;
    logic [1:0]  div1_busy = '0;

    always #2.5 clk = ~clk;

    cpu_clk_seq #(.LOCK_TIME(LT), .INIT_LEVEL(0), .DIV1_INIT(D1INI)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cur(req_cur), .req_tgt(req_tgt),
        .busy(busy), .done(done), .core_src_alt(core_src_alt), .mux_stat(mux_stat),
        .pll_cfg(pll_cfg), .pll_lock(pll_lock), .div0_cfg(div0_cfg), .div0_busy(div0_busy),
        .div1_cfg(div1_cfg), .div1_busy(div1_busy)
    );

    // Expected tables written from the requirements.
    int bm[5]  = '{150, 250, 200, 250, 200};
    int bp[5]  = '{3, 6, 6, 6, 6};
    int bs[5]  = '{1, 1, 1, 2, 3};
    int bcp[5] = '{5, 4, 3, 3, 3};
    int d0f[5][7] = '{'{0,3,7,3,4,1,7}, '{0,3,7,3,4,1,7}, '{0,3,7,3,3,1,7},
                      '{0,3,7,3,3,1,7}, '{0,1,3,1,3,1,0}};

    int errors = 0, checks = 0;
    bit finished = 0;
    int lock_delay = 2;

    function automatic logic [31:0] exp_cfg(int l);
        return (32'(bm[l]) << 16) | (32'(bp[l]) << 8) | 32'(bs[l]);
    endfunction
    function automatic logic [27:0] exp_d0(int l);
        logic [27:0] w = '0;
        for (int i = 0; i < 7; i++) w = w | (28'(d0f[l][i]) << (4 * i));
        return w;
    endfunction
    function automatic logic [31:0] exp_d1(int l);
        return (D1INI & ~32'h77) | (32'(bcp[l]) << 4);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Controller models and event monitor, all at the falling edge.
    int tcyc = 0, mux_cnt = 0, lock_cnt = 0, d0_cnt = 0, d1_cnt = 0;
    logic        prev_alt = 0;
    logic [31:0] prev_cfg = '0, prev_d1 = '0;
    logic [27:0] prev_d0 = '0;
    int cfg_cyc, mp_cyc, div_cyc, d1_cyc, fall_cyc, d0_last_busy, alt_rises, done_n;

    task automatic clear_mon();
        cfg_cyc = -1; mp_cyc = -1; div_cyc = -1; d1_cyc = -1; fall_cyc = -1;
        d0_last_busy = -1; alt_rises = 0; done_n = 0;
    endtask

    always @(negedge clk) begin
        tcyc++;
        if (!rst_n) begin
            mux_stat = 3'd1; pll_lock = 1'b1; div0_busy = '0; div1_busy = '0;
        end else begin
            if (core_src_alt != prev_alt) begin mux_cnt = 3; mux_stat = 3'd4; end
            else if (mux_cnt > 0) begin
                mux_cnt--;
                if (mux_cnt == 0) mux_stat = core_src_alt ? 3'd2 : 3'd1;
            end
            if (pll_cfg[25:8] != prev_cfg[25:8]) begin pll_lock = 1'b0; lock_cnt = lock_delay; end
            else if (!pll_lock) begin
                if (lock_cnt > 0) lock_cnt--;
                if (lock_cnt == 0) pll_lock = 1'b1;
            end
            if (div0_cfg != prev_d0) d0_cnt = 3; else if (d0_cnt > 0) d0_cnt--;
            if (div1_cfg != prev_d1) d1_cnt = 3; else if (d1_cnt > 0) d1_cnt--;
            div0_busy = (d0_cnt > 0) ? 7'h7F : 7'h00;
            div1_busy = (d1_cnt > 0) ? 2'b11 : 2'b00;
            if (div0_busy != 0) d0_last_busy = tcyc;
            if (pll_cfg != prev_cfg && cfg_cyc < 0) cfg_cyc = tcyc;
            if (pll_cfg[25:8] != prev_cfg[25:8]) mp_cyc = tcyc;
            if ((div0_cfg != prev_d0 || div1_cfg != prev_d1) && div_cyc < 0) div_cyc = tcyc;
            if (div1_cfg != prev_d1) d1_cyc = tcyc;
            if (core_src_alt && !prev_alt) alt_rises++;
            if (!core_src_alt && prev_alt) fall_cyc = tcyc;
            if (done) done_n++;
        end
        prev_alt = core_src_alt; prev_cfg = pll_cfg; prev_d0 = div0_cfg; prev_d1 = div1_cfg;
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wait_done();
        for (int w = 0; w < 2000 && done_n == 0; w++) tick();
        repeat (3) tick();
    endtask

    task automatic move(input int cur, input int tgt, input int ldly);
        logic [31:0] cfg0;
        bit full, faster;
        cfg0 = pll_cfg;
        lock_delay = ldly;
        clear_mon();
        req_valid = 1'b1; req_cur = 3'(cur); req_tgt = 3'(tgt);
        tick();
        req_valid = 1'b0;
        chk("R11 busy after accept", 64'(busy), 64'd1);
        wait_done();
        full   = (bm[cur] != bm[tgt]) || (bp[cur] != bp[tgt]);
        faster = tgt < cur;
        chk("R1 pll word", 64'(pll_cfg), 64'(exp_cfg(tgt)));
        chk("R2 divider group 0", 64'(div0_cfg), 64'(exp_d0(tgt)));
        chk("R3 divider group 1", 64'(div1_cfg), 64'(exp_d1(tgt)));
        chk("R12 single done", 64'(done_n), 64'd1);
        chk("R11 busy cleared", 64'(busy), 64'd0);
        chk("R7 main source at end", 64'(core_src_alt), 64'd0);
        if (full) begin
            chk("R5 one park on alternate", 64'(alt_rises), 64'd1);
            chk("R6 relock window", 64'((fall_cyc - mp_cyc) >= LT && (fall_cyc - mp_cyc) >= ldly), 64'd1);
        end else begin
            chk("R8 no park", 64'(alt_rises), 64'd0);
            chk("R8 upper bits kept", 64'(pll_cfg[31:3]), 64'(cfg0[31:3]));
        end
        if (div_cyc >= 0)
            chk("R4 step order", 64'(faster ? (div_cyc < cfg_cyc) : (cfg_cyc < div_cyc)), 64'd1);
        if (d1_cyc >= 0 && d0_last_busy >= 0)
            chk("R9 group 1 after group 0 idle", 64'(d1_cyc > d0_last_busy), 64'd1);
    endtask

    int cur_lvl = 0;

    initial begin
        clear_mon();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset pll word", 64'(pll_cfg), 64'(exp_cfg(0)));
        chk("R2 reset group 0", 64'(div0_cfg), 64'(exp_d0(0)));
        chk("R3 reset group 1", 64'(div1_cfg), 64'(exp_d1(0)));
        chk("R11 reset busy", 64'(busy), 64'd0);
        chk("R12 reset done", 64'(done), 64'd0);

        // Every ordered pair of distinct levels, with fast and slow lock.
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                if (a != b) begin
                    if (cur_lvl != a) move(cur_lvl, a, 2);
                    move(a, b, ((a + b) % 2 == 1) ? 2 : LT + 7);
                    cur_lvl = b;
                end
            end
        end

        // R10: equal indices finish at once and touch nothing.
        for (int l = 0; l < 5; l++) begin
            logic [31:0] c0, d10;
            logic [27:0] d00;
            if (cur_lvl != l) begin move(cur_lvl, l, 2); cur_lvl = l; end
            c0 = pll_cfg; d00 = div0_cfg; d10 = div1_cfg;
            clear_mon();
            req_valid = 1'b1; req_cur = 3'(l); req_tgt = 3'(l);
            tick();
            req_valid = 1'b0;
            chk("R10 done next cycle", 64'(done), 64'd1);
            chk("R10 not busy", 64'(busy), 64'd0);
            tick();
            chk("R12 done drops", 64'(done), 64'd0);
            chk("R10 pll word unchanged", 64'(pll_cfg), 64'(c0));
            chk("R10 group 0 unchanged", 64'(div0_cfg), 64'(d00));
            chk("R10 group 1 unchanged", 64'(div1_cfg), 64'(d10));
            chk("R10 no source switch", 64'(alt_rises), 64'd0);
        end

        // R11: a request made while busy is ignored.
        if (cur_lvl != 4) begin move(cur_lvl, 4, 2); cur_lvl = 4; end
        clear_mon();
        lock_delay = 2;
        req_valid = 1'b1; req_cur = 3'd4; req_tgt = 3'd0;
        tick();
        req_valid = 1'b0;
        repeat (4) tick();
        chk("R11 busy mid change", 64'(busy), 64'd1);
        req_valid = 1'b1; req_cur = 3'd0; req_tgt = 3'd3;
        tick();
        req_valid = 1'b0;
        wait_done();
        repeat (40) tick();
        chk("R11 late request ignored", 64'(pll_cfg), 64'(exp_cfg(0)));
        chk("R11 one done only", 64'(done_n), 64'd1);
        chk("R11 idle after", 64'(busy), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule